// File: doc/BRIEF.md
# Write-Back Cache Miss Controller

This block sits between a processor's load/store port and a word-addressed main memory whose latency is not fixed. It holds a direct-mapped cache with two-word lines inside it. Every processor request is first run as a tag compare against the cache. A hit is finished from the cache alone. A miss first writes the displaced line back to memory when that line is both valid and modified. It then fetches the two words of the wanted line, installs them, and runs the compare a second time, which now hits.

The processor raises a read or write strobe together with an address and, for a write, data. It holds all of them until it sees a one-cycle completion pulse. The memory side uses a strobe, read and write qualifiers, an address and write data. The block waits for a ready pulse from memory, with no upper bound on the wait.

Top module: `wb_cache_ctrl`

## Requirements
- R1: The request address is split as word select in bit 0, line index in bits IDX_W:1 and tag in the remaining upper TAG_W bits. Two addresses with the same index and different tags compete for one line.
- R2: A read hit raises `cpu_ok` exactly 3 cycles after the first cycle in which the request is presented. `cpu_rdata` then holds the stored word, and no memory transaction takes place.
- R3: A write hit stores the word in the cache, finishes in the same 3 cycles with no memory transaction, and marks the line modified.
- R4: A miss on a valid modified line writes that line back as two memory writes before any read. Word 0 goes first, at address {stored tag, index, 0}, and word 1 follows at {stored tag, index, 1}.
- R5: A miss on an invalid or unmodified line issues no memory write.
- R6: A miss reads word 0 and then word 1 of the requested line from memory, installs both words, and a read then returns the requested word.
- R7: A write miss, after the refill, stores the new word and leaves the line modified. A later eviction of that line writes the new word to memory.
- R8: While the memory strobe is high and ready has not been seen, the strobe, the address and the write data stay unchanged, for any number of wait cycles.
- R9: After each memory ready the strobe is low for at least one cycle before the next transaction starts, including between two writes.
- R10: `cpu_ok` is high for exactly one cycle per request.
- R11: After reset all lines are invalid, and `cpu_ok` and `mem_as` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_rd | input | 1 | Read request, held until `cpu_ok` |
| cpu_wr | input | 1 | Write request, held until `cpu_ok` |
| cpu_addr | input | TAG_W+IDX_W+1 | Word address of the request |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid while `cpu_ok` is high for a read |
| cpu_ok | output | 1 | One-cycle completion pulse |
| mem_as | output | 1 | Memory strobe |
| mem_rd | output | 1 | Memory read qualifier |
| mem_wr | output | 1 | Memory write qualifier |
| mem_addr | output | TAG_W+IDX_W+1 | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory transaction complete |

## Verification
The bench builds the block with TAG_W=3, IDX_W=2 and DATA_W=16. This gives four lines over a 64-word memory, small enough that the bench models all of memory. At that size, random addresses collide on a line often, so clean evictions, dirty write-backs and write misses all occur in a short run. The bench's memory model changes its latency on every transaction, from 0 to 9 extra cycles. This exercises the hold-until-ready behaviour and the strobe gap between write-back and refill.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CMP,
    ST_CHK,
    ST_WB_RD0,
    ST_WB_W0,
    ST_WB_RD1,
    ST_WB_W1,
    ST_GAP,
    ST_RF_R0,
    ST_RF_S0,
    ST_RF_R1,
    ST_RF_S1
  } wbc_state_e;

endpackage

// File: rtl/wbc_array.sv
module wbc_array #(
  parameter int TAG_W  = 7,
  parameter int IDX_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              access,
  input  logic              write,
  input  logic [TAG_W-1:0]  tag_in,
  input  logic [IDX_W-1:0]  idx,
  input  logic              word,
  input  logic [DATA_W-1:0] din,
  output logic              hit,
  output logic              valid_o,
  output logic              dirty_o,
  output logic [TAG_W-1:0]  tag_out,
  output logic [DATA_W-1:0] dout
);

  localparam int SETS  = 1 << IDX_W;
  localparam int WORDS = SETS * 2;

  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [DATA_W-1:0] data_mem [WORDS];
  logic [SETS-1:0]   valid_v;
  logic [SETS-1:0]   dirty_v;

  logic hit_now;
  logic data_we;

  assign hit_now = valid_v[idx] && (tag_mem[idx] == tag_in);
  assign data_we = en && write && (access || hit_now);

  // data store: one port, read-first, synchronous read
  always_ff @(posedge clk) begin
    if (en) begin
      if (data_we) data_mem[{idx, word}] <= din;
      dout <= data_mem[{idx, word}];
    end
  end

  always_ff @(posedge clk) begin
    if (en && write && access) tag_mem[idx] <= tag_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_v <= '0;
      dirty_v <= '0;
      hit     <= 1'b0;
      valid_o <= 1'b0;
      dirty_o <= 1'b0;
      tag_out <= '0;
    end else if (en) begin
      hit     <= !access && hit_now;
      valid_o <= valid_v[idx];
      dirty_o <= dirty_v[idx];
      tag_out <= tag_mem[idx];
      if (write && access) begin
        valid_v[idx] <= 1'b1;
        dirty_v[idx] <= 1'b0;
      end else if (write && hit_now) begin
        dirty_v[idx] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/wbc_fsm.sv
module wbc_fsm
  import wbc_pkg::*;
#(
  parameter int TAG_W  = 7,
  parameter int IDX_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cpu_rd,
  input  logic                   cpu_wr,
  input  logic [TAG_W+IDX_W:0]   cpu_addr,
  input  logic [DATA_W-1:0]      cpu_wdata,
  output logic [DATA_W-1:0]      cpu_rdata,
  output logic                   cpu_ok,
  output logic                   c_en,
  output logic                   c_access,
  output logic                   c_write,
  output logic [TAG_W-1:0]       c_tag,
  output logic [IDX_W-1:0]       c_idx,
  output logic                   c_word,
  output logic [DATA_W-1:0]      c_din,
  input  logic                   c_hit,
  input  logic                   c_valid,
  input  logic                   c_dirty,
  input  logic [TAG_W-1:0]       c_tag_out,
  input  logic [DATA_W-1:0]      c_dout,
  output logic                   mem_as,
  output logic                   mem_rd,
  output logic                   mem_wr,
  output logic [TAG_W+IDX_W:0]   mem_addr,
  output logic [DATA_W-1:0]      mem_wdata,
  input  logic [DATA_W-1:0]      mem_rdata,
  input  logic                   mem_ready
);

  localparam int ADDR_W = TAG_W + IDX_W + 1;

  wbc_state_e state, nxt;

  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic              req_wr;
  logic [DATA_W-1:0] fill_q;
  logic              refilled;

  logic [TAG_W-1:0] req_tag;
  logic [IDX_W-1:0] req_idx;
  logic             req_word;

  assign req_word = req_addr[0];
  assign req_idx  = req_addr[IDX_W:1];
  assign req_tag  = req_addr[ADDR_W-1:IDX_W+1];

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:   if ((cpu_rd || cpu_wr) && !cpu_ok) nxt = ST_CMP;
      ST_CMP:    nxt = ST_CHK;
      ST_CHK: begin
        if (c_hit)                 nxt = ST_IDLE;
        else if (c_valid && c_dirty) nxt = ST_WB_RD0;
        else                       nxt = ST_RF_R0;
      end
      ST_WB_RD0: nxt = ST_WB_W0;
      ST_WB_W0:  if (mem_ready) nxt = ST_WB_RD1;
      ST_WB_RD1: nxt = ST_WB_W1;
      ST_WB_W1:  if (mem_ready) nxt = ST_GAP;
      ST_GAP:    nxt = ST_RF_R0;
      ST_RF_R0:  if (mem_ready) nxt = ST_RF_S0;
      ST_RF_S0:  nxt = ST_RF_R1;
      ST_RF_R1:  if (mem_ready) nxt = ST_RF_S1;
      ST_RF_S1:  nxt = ST_CMP;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cpu_ok    <= 1'b0;
      cpu_rdata <= '0;
      req_addr  <= '0;
      req_wdata <= '0;
      req_wr    <= 1'b0;
      fill_q    <= '0;
      refilled  <= 1'b0;
    end else begin
      state  <= nxt;
      cpu_ok <= 1'b0;
      if (state == ST_IDLE && nxt == ST_CMP) begin
        req_addr  <= cpu_addr;
        req_wdata <= cpu_wdata;
        req_wr    <= cpu_wr;
      end
      if (state == ST_CHK && c_hit) begin
        cpu_ok <= 1'b1;
        if (!req_wr) cpu_rdata <= c_dout;
      end
      if ((state == ST_RF_R0 || state == ST_RF_R1) && mem_ready) fill_q <= mem_rdata;
      if (state == ST_RF_S1)     refilled <= 1'b1;
      else if (state == ST_IDLE) refilled <= 1'b0;
    end
  end

  // cache port control
  always_comb begin
    c_en     = 1'b0;
    c_access = 1'b0;
    c_write  = 1'b0;
    c_word   = req_word;
    c_din    = req_wdata;
    case (state)
      ST_CMP: begin
        c_en    = 1'b1;
        c_write = req_wr;
      end
      ST_WB_RD0, ST_WB_RD1: begin
        c_en     = 1'b1;
        c_access = 1'b1;
        c_word   = (state == ST_WB_RD1);
      end
      ST_RF_S0, ST_RF_S1: begin
        c_en     = 1'b1;
        c_access = 1'b1;
        c_write  = 1'b1;
        c_word   = (state == ST_RF_S1);
        c_din    = fill_q;
      end
      default: ;
    endcase
  end

  assign c_tag = req_tag;
  assign c_idx = req_idx;

  // memory port: write-back data and tag come from the held cache outputs
  assign mem_wr    = (state == ST_WB_W0) || (state == ST_WB_W1);
  assign mem_rd    = (state == ST_RF_R0) || (state == ST_RF_R1);
  assign mem_as    = mem_wr || mem_rd;
  assign mem_addr  = {(mem_wr ? c_tag_out : req_tag), req_idx,
                      (state == ST_WB_W1) || (state == ST_RF_R1)};
  assign mem_wdata = c_dout;

  // R10: completion is a single-cycle pulse
  a_r10_ok_pulse: assert property (@(posedge clk) disable iff (rst)
    cpu_ok |=> !cpu_ok);

  // R8: strobe, address and data held while waiting for ready
  a_r8_hold_until_ready: assert property (@(posedge clk) disable iff (rst)
    (mem_as && !mem_ready) |=> (mem_as && $stable(mem_addr) && $stable(mem_wdata)
                                && $stable(mem_wr)));

  // R9: strobe drops after every ready
  a_r9_strobe_gap: assert property (@(posedge clk) disable iff (rst)
    (mem_as && mem_ready) |=> !mem_as);

  // R6: the compare after a refill always hits
  a_r6_refill_hits: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CHK && refilled) |-> c_hit);

  // R2: a hit ends without touching memory
  a_r2_hit_no_mem: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CHK && c_hit) |=> !mem_as);

endmodule

// File: rtl/wb_cache_ctrl.sv
module wb_cache_ctrl #(
  parameter int TAG_W  = 7,
  parameter int IDX_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cpu_rd,
  input  logic                 cpu_wr,
  input  logic [TAG_W+IDX_W:0] cpu_addr,
  input  logic [DATA_W-1:0]    cpu_wdata,
  output logic [DATA_W-1:0]    cpu_rdata,
  output logic                 cpu_ok,
  output logic                 mem_as,
  output logic                 mem_rd,
  output logic                 mem_wr,
  output logic [TAG_W+IDX_W:0] mem_addr,
  output logic [DATA_W-1:0]    mem_wdata,
  input  logic [DATA_W-1:0]    mem_rdata,
  input  logic                 mem_ready
);

  logic              c_en, c_access, c_write, c_word;
  logic [TAG_W-1:0]  c_tag, c_tag_out;
  logic [IDX_W-1:0]  c_idx;
  logic [DATA_W-1:0] c_din, c_dout;
  logic              c_hit, c_valid, c_dirty;

  wbc_fsm #(.TAG_W(TAG_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ok(cpu_ok),
    .c_en(c_en), .c_access(c_access), .c_write(c_write), .c_tag(c_tag),
    .c_idx(c_idx), .c_word(c_word), .c_din(c_din),
    .c_hit(c_hit), .c_valid(c_valid), .c_dirty(c_dirty),
    .c_tag_out(c_tag_out), .c_dout(c_dout),
    .mem_as(mem_as), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  wbc_array #(.TAG_W(TAG_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst(rst),
    .en(c_en), .access(c_access), .write(c_write), .tag_in(c_tag),
    .idx(c_idx), .word(c_word), .din(c_din),
    .hit(c_hit), .valid_o(c_valid), .dirty_o(c_dirty),
    .tag_out(c_tag_out), .dout(c_dout)
  );

endmodule

// File: tb/test_wb_cache_ctrl.sv
module test_wb_cache_ctrl;

  localparam int TAG_W  = 3;
  localparam int IDX_W  = 2;
  localparam int DATA_W = 16;
  localparam int ADDR_W = TAG_W + IDX_W + 1;
  localparam int MWORDS = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic              cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic [DATA_W-1:0] cpu_rdata;
  logic              cpu_ok;
  logic              mem_as, mem_rd, mem_wr;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata = '0;
  logic              mem_ready = 1'b0;

  wb_cache_ctrl #(.TAG_W(TAG_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) i_wb_cache_ctrl (
    .clk(clk), .rst(rst),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ok(cpu_ok),
    .mem_as(mem_as), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit good, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory model with latency that changes per transaction
  logic [DATA_W-1:0] mem_model [MWORDS];
  logic [DATA_W-1:0] ref_mem   [MWORDS];
  bit                m_busy = 0, m_drop = 0, m_wr = 0;
  int                m_cnt = 0, m_lat = 0;
  logic [ADDR_W-1:0] m_addr = '0;
  logic [DATA_W-1:0] m_data = '0;
  int                n_wr = 0, n_rd = 0;
  logic [ADDR_W-1:0] wlog_prev = '0, wlog_last = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0;
      m_drop = 0;
      mem_ready <= 1'b0;
    end else begin
      mem_ready <= 1'b0;
      if (!mem_as) m_drop = 0;
      if (m_busy) begin
        if (m_cnt == 0) begin
          if (m_wr) begin
            mem_model[m_addr] = m_data;
            n_wr++;
            wlog_prev = wlog_last;
            wlog_last = m_addr;
          end else begin
            mem_rdata <= mem_model[m_addr];
            n_rd++;
          end
          mem_ready <= 1'b1;
          m_busy = 0;
          m_drop = 1;
        end else begin
          m_cnt--;
        end
      end else if (mem_as && !m_drop && (mem_rd || mem_wr)) begin
        m_busy = 1;
        m_wr   = mem_wr;
        m_addr = mem_addr;
        m_data = mem_wdata;
        m_cnt  = m_lat;
        m_lat  = (m_lat + 3) % 10;
      end
    end
  end

  // protocol monitor: hold while waiting (R8), gap after ready (R9)
  bit prev_ready = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (m_busy) chk(mem_as && mem_addr == m_addr, "R8", mem_addr, m_addr);
      if (prev_ready) chk(!mem_as, "R9", mem_as, 0);
    end
    prev_ready = mem_ready;
  end

  // scoreboard
  logic [DATA_W-1:0] exp_q [$];
  bit                rdq   [$];
  string             tagq  [$];

  always @(negedge clk) begin
    if (cpu_ok) begin
      if (exp_q.size() == 0) begin
        chk(0, "R10", 1, 0);
      end else begin
        logic [DATA_W-1:0] e;
        bit r;
        string t;
        e = exp_q.pop_front();
        r = rdq.pop_front();
        t = tagq.pop_front();
        if (r) chk(cpu_rdata == e, t, cpu_rdata, e);
      end
    end
  end

  // driver: call just after a falling edge
  task automatic op(input bit w, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                    input string req, output int cyc);
    exp_q.push_back(ref_mem[a]);
    rdq.push_back(!w);
    tagq.push_back(req);
    if (w) ref_mem[a] = d;
    cpu_rd = !w;
    cpu_wr = w;
    cpu_addr = a;
    cpu_wdata = d;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_ok && cyc < 3000);
    if (!cpu_ok) chk(0, "R10", 0, 1);
    cpu_rd = 1'b0;
    cpu_wr = 1'b0;
    @(negedge clk);
    chk(!cpu_ok, "R10", cpu_ok, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc, w0, r0;
    logic [15:0] lfsr;
    for (int i = 0; i < MWORDS; i++) begin
      mem_model[i] = 16'hA000 + 16'(i);
      ref_mem[i]   = 16'hA000 + 16'(i);
    end
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!cpu_ok, "R11", cpu_ok, 0);
    chk(!mem_as, "R11", mem_as, 0);

    // clean miss on invalid line: tag0 idx2 word1
    w0 = n_wr; r0 = n_rd;
    op(0, 6'h05, 0, "R6", cyc);
    chk(n_wr == w0, "R5", n_wr - w0, 0);
    chk(n_rd == r0 + 2, "R6", n_rd - r0, 2);

    // hit on the other word of the same line
    r0 = n_rd;
    op(0, 6'h04, 0, "R2", cyc);
    chk(cyc == 3, "R2", cyc, 3);
    chk(n_rd == r0, "R2", n_rd - r0, 0);

    // write hit
    w0 = n_wr; r0 = n_rd;
    op(1, 6'h04, 16'h1234, "R3", cyc);
    chk(cyc == 3, "R3", cyc, 3);
    chk(n_wr == w0 && n_rd == r0, "R3", n_wr - w0 + n_rd - r0, 0);
    op(0, 6'h04, 0, "R3", cyc);

    // conflict (tag1 idx2) evicts the dirty line
    w0 = n_wr;
    op(0, 6'h0C, 0, "R1", cyc);
    chk(n_wr == w0 + 2, "R4", n_wr - w0, 2);
    chk(wlog_prev == 6'h04, "R4", wlog_prev, 6'h04);
    chk(wlog_last == 6'h05, "R4", wlog_last, 6'h05);
    chk(mem_model[6'h04] == 16'h1234, "R4", mem_model[6'h04], 16'h1234);

    // back to tag0: victim is clean
    w0 = n_wr;
    op(0, 6'h04, 0, "R4", cyc);
    chk(n_wr == w0, "R5", n_wr - w0, 0);

    // write miss on invalid line tag2 idx1 word1
    w0 = n_wr; r0 = n_rd;
    op(1, 6'h13, 16'hBEEF, "R7", cyc);
    chk(n_wr == w0 && n_rd == r0 + 2, "R7", n_rd - r0, 2);
    op(0, 6'h13, 0, "R7", cyc);
    chk(cyc == 3, "R7", cyc, 3);
    op(0, 6'h12, 0, "R6", cyc);

    // evict the write-miss line
    w0 = n_wr;
    op(0, 6'h33, 0, "R7", cyc);
    chk(n_wr == w0 + 2, "R7", n_wr - w0, 2);
    chk(mem_model[6'h13] == 16'hBEEF, "R7", mem_model[6'h13], 16'hBEEF);

    // write miss onto a dirty line
    op(1, 6'h05, 16'h5555, "R3", cyc);
    w0 = n_wr;
    op(1, 6'h2D, 16'h7777, "R4", cyc);
    chk(n_wr == w0 + 2, "R4", n_wr - w0, 2);
    chk(mem_model[6'h05] == 16'h5555, "R4", mem_model[6'h05], 16'h5555);
    op(0, 6'h2D, 0, "R7", cyc);

    // random traffic with varying memory latency
    lfsr = 16'hACE1;
    for (int k = 0; k < 80; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      op(lfsr[6], lfsr[5:0], lfsr ^ 16'h5A5A, "R8", cyc);
    end
    for (int a = 0; a < MWORDS; a++) op(0, 6'(a), 0, "R6", cyc);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule